// File: doc/BRIEF.md
# Debug Register Access Engine

This engine performs one register read or register write on a remote module reached over a 16-bit packet interconnect used for debug. A command supplies the target's address on the interconnect, the engine's own address, the access width (16, 32, 64 or 128 bits), a 16-bit register address, a write value and a read/write select. The engine turns the command into a request packet and sends it one 16-bit flit at a time over a ready/valid stream. It then waits for the reply packet on a second stream.

The reply is checked as it arrives. For reads, the engine checks the addressing and the type field, then the subtype. It also checks that the number of payload words matches the width. The read value is assembled from the payload words, with the first word received ending up most significant. For writes only the subtype decides the outcome. If no complete reply arrives within a fixed number of cycles, the transaction ends with a timeout.

Each transaction ends with a one-cycle completion pulse together with a pass flag, a 3-bit error code and the read value.

Top module: `dbg_reg_xact`

## Requirements
- R1: A request packet sends its flits in this order: target address, own address, a type/subtype flit, then the register address. A read request is exactly these 4 flits. `tx_last` is high only on the final flit of a packet.
- R2: A write request carries width/16 value flits after the register address, most significant word first, so the packet is 4 + width/16 flits long.
- R3: In the type/subtype flit, bits [15:10] carry the register-access type code 1 and bits [9:0] carry the subtype. Read requests use subtypes 0, 1, 2 and 3 for widths 16, 32, 64 and 128. Write requests use subtypes 4, 5, 6 and 7 for the same widths.
- R4: A command whose width is not 16, 32, 64 or 128 sends no flit. One cycle after it is accepted, `done` pulses with error code 1.
- R5: A read reply is rejected with error code 2 in any of these cases: its first flit differs from the own address, its second flit differs from the target address, or its type field differs from 1.
- R6: If the header of a read reply is correct, subtype 12 gives error code 3. Any subtype other than the success code for the requested width gives error code 4. The success codes are 8, 9, 10 and 11 for widths 16, 32, 64 and 128.
- R7: A read reply with the correct header and success subtype must carry exactly width/16 payload flits, otherwise error code 5 is reported. When the count is right, `rdata` holds the value with payload word w placed at bits (n-1-w)*16, right-aligned. A reply that ends before its third flit also reports error code 5.
- R8: A write reply with subtype 13 succeeds. Subtype 14 gives error code 6 and any other subtype gives error code 4. The address and type flits of a write reply are not checked.
- R9: Suppose no complete reply arrives within TIMEOUT_CYC cycles after the last request flit is accepted. Then `done` pulses with error code 7 exactly TIMEOUT_CYC cycles after that handshake edge.
- R10: `rx_ready` is always high. Flits that arrive while no reply is awaited are discarded. This includes the remaining flits of a packet that began before the wait started. None of these flits affects any transaction outcome.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_flit` and `tx_last` hold their values.
- R12: `done` pulses for one cycle, on the cycle after the final reply flit is accepted. `ok` is 1 exactly when `err` is 0. `rdata` is 0 unless the transaction was a successful read. `cmd_ready` is high only while idle. After reset, `cmd_ready`=1 and `done`, `ok`, `err` and `tx_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle; command accepted when both high |
| cmd_write | input | 1 | 1 = register write, 0 = register read |
| cmd_width | input | 8 | Access width in bits (16, 32, 64, 128) |
| cmd_dest | input | 16 | Target module address |
| cmd_src | input | 16 | Own address |
| cmd_addr | input | 16 | Register address |
| cmd_wdata | input | 128 | Write value, right-aligned |
| tx_valid | output | 1 | Request flit valid |
| tx_flit | output | 16 | Request flit |
| tx_last | output | 1 | Final flit of request packet |
| tx_ready | input | 1 | Request flit accepted |
| rx_valid | input | 1 | Reply flit valid |
| rx_flit | input | 16 | Reply flit |
| rx_last | input | 1 | Final flit of reply packet |
| rx_ready | output | 1 | Reply flit accepted (constant 1) |
| done | output | 1 | Transaction complete pulse |
| ok | output | 1 | Last transaction succeeded |
| err | output | 3 | Last transaction error code |
| rdata | output | 128 | Last read value, right-aligned |

## Verification
The assertions assume a command is offered only while `cmd_ready` is high. They also assume the interconnect never starts a new packet while `tx_last` of the previous one is still pending, and that every reply packet ends with `rx_last`. The bench drives commands only from the idle state and throttles `tx_ready` in a repeating pattern. Every packet it injects, including the stray ones, is well framed. A stray packet is deliberately split around the start of a transaction, so the tail-discard rule is exercised without breaking framing.

// File: rtl/dbgx_pkg.sv
`timescale 1ns/1ps
package dbgx_pkg;
    localparam int FLIT_W    = 16;
    localparam int MAX_BITS  = 128;
    localparam int MAX_WORDS = MAX_BITS / FLIT_W;
    localparam int TYPE_W    = 6;
    localparam int SUB_W     = FLIT_W - TYPE_W;
    localparam int HDR_FLITS = 3;
    localparam int POS_W     = $clog2(HDR_FLITS + MAX_WORDS + 2) + 1;

    localparam logic [TYPE_W-1:0] TYPE_REG   = 6'd1;
    localparam logic [SUB_W-1:0]  SUB_RD_REQ = 10'd0;
    localparam logic [SUB_W-1:0]  SUB_WR_REQ = 10'd4;
    localparam logic [SUB_W-1:0]  SUB_RD_OK  = 10'd8;
    localparam logic [SUB_W-1:0]  SUB_RD_ERR = 10'd12;
    localparam logic [SUB_W-1:0]  SUB_WR_OK  = 10'd13;
    localparam logic [SUB_W-1:0]  SUB_WR_ERR = 10'd14;

    typedef enum logic [2:0] {
        E_NONE   = 3'd0,
        E_WIDTH  = 3'd1,
        E_HDR    = 3'd2,
        E_RDFAIL = 3'd3,
        E_SUB    = 3'd4,
        E_LEN    = 3'd5,
        E_WRFAIL = 3'd6,
        E_TMO    = 3'd7
    } err_e;
endpackage

// File: rtl/dbgx_req_tx.sv
`timescale 1ns/1ps
module dbgx_req_tx
    import dbgx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [FLIT_W-1:0]   dest,
    input  logic [FLIT_W-1:0]   src,
    input  logic [FLIT_W-1:0]   addr,
    input  logic [MAX_BITS-1:0] wdata,
    input  logic                write,
    input  logic [1:0]          widx,
    output logic                tx_valid,
    output logic [FLIT_W-1:0]   tx_flit,
    output logic                tx_last,
    input  logic                tx_ready,
    output logic                sent
);
    typedef struct packed {
        logic                busy;
        logic [POS_W-1:0]    idx;
        logic [POS_W-1:0]    last_idx;
        logic [FLIT_W-1:0]   dest;
        logic [FLIT_W-1:0]   src;
        logic [FLIT_W-1:0]   hdr;
        logic [FLIT_W-1:0]   addr;
        logic [MAX_BITS-1:0] pay;
    } tx_st_t;

    tx_st_t s_d, s_q;
    logic [SUB_W-1:0] sub_sel;
    logic fire;

    always_comb begin
        s_d     = s_q;
        fire    = s_q.busy && tx_ready;
        sub_sel = (write ? SUB_WR_REQ : SUB_RD_REQ) + SUB_W'(widx);
        if (start) begin
            s_d.busy     = 1'b1;
            s_d.idx      = '0;
            s_d.last_idx = write ? POS_W'(HDR_FLITS) + (POS_W'(1) << widx) : POS_W'(HDR_FLITS);
            s_d.dest     = dest;
            s_d.src      = src;
            s_d.addr     = addr;
            s_d.hdr      = {TYPE_REG, sub_sel};
            s_d.pay      = wdata << (MAX_BITS - (FLIT_W << widx));
        end else if (fire) begin
            if (s_q.idx == s_q.last_idx) s_d.busy = 1'b0;
            s_d.idx = s_q.idx + POS_W'(1);
            if (s_q.idx > POS_W'(HDR_FLITS)) s_d.pay = s_q.pay << FLIT_W;
        end
    end

    always_comb begin
        unique case (s_q.idx)
            POS_W'(0): tx_flit = s_q.dest;
            POS_W'(1): tx_flit = s_q.src;
            POS_W'(2): tx_flit = s_q.hdr;
            POS_W'(3): tx_flit = s_q.addr;
            default:   tx_flit = s_q.pay[MAX_BITS-1 -: FLIT_W];
        endcase
    end

    assign tx_valid = s_q.busy;
    assign tx_last  = s_q.busy && (s_q.idx == s_q.last_idx);
    assign sent     = fire && (s_q.idx == s_q.last_idx);

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R11: a stalled flit keeps its value
    a_r11_hold_flit: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_flit) && $stable(tx_last));

    // R1: one packet per command, nothing right after its final flit
    a_r1_single_packet: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last |=> !tx_valid);
endmodule

// File: rtl/dbgx_rsp_rx.sv
`timescale 1ns/1ps
module dbgx_rsp_rx
    import dbgx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                write,
    input  logic [1:0]          widx,
    input  logic [FLIT_W-1:0]   own,
    input  logic [FLIT_W-1:0]   target,
    input  logic                rx_valid,
    input  logic [FLIT_W-1:0]   rx_flit,
    input  logic                rx_last,
    output logic                rsp_done,
    output err_e                rsp_err,
    output logic [MAX_BITS-1:0] rsp_data
);
    typedef struct packed {
        logic                in_pkt;
        logic                cap;
        logic                bad;
        logic [POS_W-1:0]    pos;
        logic [SUB_W-1:0]    sub;
        logic [MAX_BITS-1:0] data;
    } rx_st_t;

    rx_st_t s_d, s_q, base;
    logic cur;
    logic [POS_W-1:0] nwords;

    always_comb begin
        s_d  = s_q;
        base = s_q;
        cur  = (s_q.in_pkt ? s_q.cap : 1'b1) && active;
        if (!s_q.in_pkt) begin
            base.pos  = '0;
            base.bad  = 1'b0;
            base.sub  = '0;
            base.data = '0;
        end
        if (rx_valid) begin
            s_d.in_pkt = !rx_last;
            s_d.cap    = cur;
            if (cur) begin
                s_d = base;
                s_d.in_pkt = !rx_last;
                s_d.cap    = cur;
                unique case (base.pos)
                    POS_W'(0): s_d.bad = base.bad | (rx_flit != own);
                    POS_W'(1): s_d.bad = base.bad | (rx_flit != target);
                    POS_W'(2): begin
                        s_d.bad = base.bad | (rx_flit[FLIT_W-1 -: TYPE_W] != TYPE_REG);
                        s_d.sub = rx_flit[SUB_W-1:0];
                    end
                    default:   s_d.data = {base.data[MAX_BITS-FLIT_W-1:0], rx_flit};
                endcase
                s_d.pos = (base.pos == '1) ? base.pos : base.pos + POS_W'(1);
            end
        end
    end

    always_comb begin
        nwords  = s_d.pos - POS_W'(HDR_FLITS);
        rsp_err = E_NONE;
        if (s_d.pos < POS_W'(HDR_FLITS))               rsp_err = E_LEN;
        else if (write) begin
            if (s_d.sub == SUB_WR_OK)                  rsp_err = E_NONE;
            else if (s_d.sub == SUB_WR_ERR)            rsp_err = E_WRFAIL;
            else                                       rsp_err = E_SUB;
        end
        else if (s_d.bad)                              rsp_err = E_HDR;
        else if (s_d.sub == SUB_RD_ERR)                rsp_err = E_RDFAIL;
        else if (s_d.sub != SUB_RD_OK + SUB_W'(widx))  rsp_err = E_SUB;
        else if (nwords != (POS_W'(1) << widx))        rsp_err = E_LEN;
        rsp_done = rx_valid && rx_last && cur;
        rsp_data = (!write && rsp_err == E_NONE) ? s_d.data : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/dbg_reg_xact.sv
`timescale 1ns/1ps
module dbg_reg_xact
    import dbgx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 256
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic                cmd_write,
    input  logic [7:0]          cmd_width,
    input  logic [FLIT_W-1:0]   cmd_dest,
    input  logic [FLIT_W-1:0]   cmd_src,
    input  logic [FLIT_W-1:0]   cmd_addr,
    input  logic [MAX_BITS-1:0] cmd_wdata,
    output logic                tx_valid,
    output logic [FLIT_W-1:0]   tx_flit,
    output logic                tx_last,
    input  logic                tx_ready,
    input  logic                rx_valid,
    input  logic [FLIT_W-1:0]   rx_flit,
    input  logic                rx_last,
    output logic                rx_ready,
    output logic                done,
    output logic                ok,
    output logic [2:0]          err,
    output logic [MAX_BITS-1:0] rdata
);
    localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);

    typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} state_e;

    typedef struct packed {
        state_e              st;
        logic                write;
        logic [1:0]          widx;
        logic [FLIT_W-1:0]   dest;
        logic [FLIT_W-1:0]   src;
        logic [TMO_W-1:0]    tmo;
        logic                done;
        logic                ok;
        err_e                err;
        logic [MAX_BITS-1:0] rdata;
    } top_st_t;

    top_st_t s_d, s_q;
    logic width_bad, start, sent, rsp_done;
    logic [1:0] cmd_widx;
    err_e rsp_err;
    logic [MAX_BITS-1:0] rsp_data;

    always_comb begin
        width_bad = 1'b0;
        cmd_widx  = 2'd0;
        unique case (cmd_width)
            8'd16:   cmd_widx = 2'd0;
            8'd32:   cmd_widx = 2'd1;
            8'd64:   cmd_widx = 2'd2;
            8'd128:  cmd_widx = 2'd3;
            default: width_bad = 1'b1;
        endcase
    end

    assign cmd_ready = (s_q.st == S_IDLE);
    assign start     = cmd_valid && cmd_ready && !width_bad;

    dbgx_req_tx u_tx (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dest(cmd_dest), .src(cmd_src), .addr(cmd_addr), .wdata(cmd_wdata),
        .write(cmd_write), .widx(cmd_widx),
        .tx_valid(tx_valid), .tx_flit(tx_flit), .tx_last(tx_last),
        .tx_ready(tx_ready), .sent(sent)
    );

    dbgx_rsp_rx u_rx (
        .clk(clk), .rst_n(rst_n), .active(s_q.st == S_WAIT),
        .write(s_q.write), .widx(s_q.widx), .own(s_q.src), .target(s_q.dest),
        .rx_valid(rx_valid), .rx_flit(rx_flit), .rx_last(rx_last),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_data(rsp_data)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            S_IDLE: if (cmd_valid) begin
                if (width_bad) begin
                    s_d.done  = 1'b1;
                    s_d.ok    = 1'b0;
                    s_d.err   = E_WIDTH;
                    s_d.rdata = '0;
                end else begin
                    s_d.st    = S_SEND;
                    s_d.write = cmd_write;
                    s_d.widx  = cmd_widx;
                    s_d.dest  = cmd_dest;
                    s_d.src   = cmd_src;
                end
            end
            S_SEND: if (sent) begin
                s_d.st  = S_WAIT;
                s_d.tmo = '0;
            end
            S_WAIT: begin
                if (rsp_done) begin
                    s_d.st    = S_IDLE;
                    s_d.done  = 1'b1;
                    s_d.ok    = (rsp_err == E_NONE);
                    s_d.err   = rsp_err;
                    s_d.rdata = rsp_data;
                end else if (s_q.tmo == TMO_W'(TIMEOUT_CYC - 1)) begin
                    s_d.st    = S_IDLE;
                    s_d.done  = 1'b1;
                    s_d.ok    = 1'b0;
                    s_d.err   = E_TMO;
                    s_d.rdata = '0;
                end else begin
                    s_d.tmo = s_q.tmo + TMO_W'(1);
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rx_ready = 1'b1;
    assign done     = s_q.done;
    assign ok       = s_q.ok;
    assign err      = s_q.err;
    assign rdata    = s_q.rdata;

    // R4: rejected width completes next cycle with no traffic
    a_r4_bad_width: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && width_bad |=> done && err == 3'd1 && !tx_valid);

    // R9: wait limit reached without a reply ends in a timeout
    a_r9_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.st == S_WAIT && s_q.tmo == TMO_W'(TIMEOUT_CYC - 1) && !rsp_done
        |=> done && err == 3'd7 && !ok);

    // R12: the engine never sends while it offers to take a command
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !tx_valid);
endmodule

// File: tb/dbg_reg_xact_test.sv
`timescale 1ns/1ps
module dbg_reg_xact_test;
    import dbgx_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TMO = 40;
    localparam logic [15:0] OWN = 16'h0007;
    localparam logic [15:0] TGT = 16'h0042;

    typedef struct packed {
        logic         wr;
        logic [7:0]   width;
        logic [15:0]  addr;
        logic [127:0] wdata;
        logic [15:0]  rdst;
        logic [15:0]  rsrc;
        logic [5:0]   rtype;
        logic [9:0]   rsub;
        logic [3:0]   rnw;
        logic [127:0] rval;
        logic [2:0]   eerr;
        logic [127:0] erdata;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 8'd16,  16'h0010, 128'h0, OWN, TGT, 6'd1, 10'd8,  4'd1, 128'hBEEF, 3'd0, 128'hBEEF},
        '{1'b0, 8'd32,  16'h0011, 128'h0, OWN, TGT, 6'd1, 10'd9,  4'd2, 128'h1234_5678, 3'd0, 128'h1234_5678},
        '{1'b0, 8'd64,  16'h0123, 128'h0, OWN, TGT, 6'd1, 10'd10, 4'd4, 128'h0123_4567_89AB_CDEF, 3'd0, 128'h0123_4567_89AB_CDEF},
        '{1'b0, 8'd128, 16'hFFFF, 128'h0, OWN, TGT, 6'd1, 10'd11, 4'd8,
          128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 3'd0, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF},
        '{1'b1, 8'd16,  16'h0020, 128'hA5A5, OWN, TGT, 6'd1, 10'd13, 4'd0, 128'h0, 3'd0, 128'h0},
        '{1'b1, 8'd128, 16'h0021, 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F, OWN, TGT, 6'd1, 10'd13, 4'd0, 128'h0, 3'd0, 128'h0},
        '{1'b1, 8'd32,  16'h0022, 128'hCAFE_F00D, OWN, TGT, 6'd1, 10'd14, 4'd0, 128'h0, 3'd6, 128'h0},
        '{1'b1, 8'd64,  16'h0023, 128'h1122_3344_5566_7788, OWN, TGT, 6'd1, 10'd8, 4'd0, 128'h0, 3'd4, 128'h0},
        '{1'b0, 8'd32,  16'h0030, 128'h0, 16'h0008, TGT, 6'd1, 10'd9, 4'd2, 128'h1, 3'd2, 128'h0},
        '{1'b0, 8'd32,  16'h0031, 128'h0, OWN, TGT, 6'd2, 10'd9, 4'd2, 128'h1, 3'd2, 128'h0},
        '{1'b0, 8'd64,  16'h0032, 128'h0, OWN, TGT, 6'd1, 10'd12, 4'd0, 128'h0, 3'd3, 128'h0},
        '{1'b0, 8'd64,  16'h0033, 128'h0, OWN, TGT, 6'd1, 10'd9, 4'd2, 128'h5, 3'd4, 128'h0},
        '{1'b0, 8'd64,  16'h0034, 128'h0, OWN, TGT, 6'd1, 10'd10, 4'd3, 128'h7, 3'd5, 128'h0},
        '{1'b0, 8'd16,  16'h0035, 128'h0, OWN, 16'h0043, 6'd1, 10'd8, 4'd1, 128'h9, 3'd2, 128'h0},
        '{1'b1, 8'd16,  16'h0036, 128'h77, 16'h0099, 16'h0098, 6'd3, 10'd13, 4'd0, 128'h0, 3'd0, 128'h0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [7:0] cmd_width = 8'd0;
    logic [15:0] cmd_dest = 16'h0, cmd_src = 16'h0, cmd_addr = 16'h0;
    logic [127:0] cmd_wdata = '0;
    logic cmd_ready, tx_valid, tx_last, rx_ready, done, ok;
    logic [15:0] tx_flit;
    logic tx_ready = 1'b1;
    logic rx_valid = 1'b0, rx_last = 1'b0;
    logic [15:0] rx_flit = 16'h0;
    logic [2:0] err;
    logic [127:0] rdata;

    int n_chk = 0, n_bad = 0, thr = 0;
    logic [15:0] txbuf [0:15];

    dbg_reg_xact #(.TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_width(cmd_width), .cmd_dest(cmd_dest), .cmd_src(cmd_src),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .tx_valid(tx_valid), .tx_flit(tx_flit), .tx_last(tx_last), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_flit(rx_flit), .rx_last(rx_last), .rx_ready(rx_ready),
        .done(done), .ok(ok), .err(err), .rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit cond, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    function automatic int words_of(input logic [7:0] w);
        case (w)
            8'd16:   return 1;
            8'd32:   return 2;
            8'd64:   return 4;
            default: return 8;
        endcase
    endfunction

    function automatic int widx_of(input logic [7:0] w);
        case (w)
            8'd16:   return 0;
            8'd32:   return 1;
            8'd64:   return 2;
            default: return 3;
        endcase
    endfunction

    function automatic string tag_of(input vec_t v);
        case (v.eerr)
            3'd2:    return "R5";
            3'd3:    return "R6";
            3'd4:    return v.wr ? "R8" : "R6";
            3'd5:    return "R7";
            3'd6:    return "R8";
            default: return v.wr ? "R8" : "R7";
        endcase
    endfunction

    task automatic issue(input logic wr, input logic [7:0] w, input logic [15:0] a,
                         input logic [127:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_width = w;
        cmd_dest = TGT; cmd_src = OWN; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic collect(output int n);
        logic [15:0] prev = 16'h0;
        bit stall = 1'b0;
        bit held = 1'b1;
        int guard = 0;
        n = 0;
        forever begin
            tx_ready = (thr % 3) != 1;
            thr++;
            #1;
            if (stall && tx_flit !== prev) held = 1'b0;
            stall = tx_valid && !tx_ready;
            prev = tx_flit;
            if (tx_valid && tx_ready) begin
                txbuf[n] = tx_flit;
                n++;
                if (tx_last) break;
            end
            guard++;
            if (guard > 60) break;
            @(negedge clk);
        end
        chk(held, "R11", "flit held while stalled", 0, 1);
    endtask

    task automatic check_req(input vec_t v, input int n);
        int nw = words_of(v.width);
        int en = v.wr ? 4 + nw : 4;
        logic [15:0] hdr = {6'd1, 10'((v.wr ? 4 : 0) + widx_of(v.width))};
        bit pay_ok = 1'b1;
        chk(n == en, "R1", "request flit count", n, en);
        if (n >= 4) begin
            chk(txbuf[0] === TGT && txbuf[1] === OWN && txbuf[3] === v.addr,
                "R1", "request address flits", {txbuf[0], txbuf[1], txbuf[3]}, {TGT, OWN, v.addr});
            chk(txbuf[2] === hdr, "R3", "request type/subtype flit", txbuf[2], hdr);
        end
        if (v.wr && n == en) begin
            for (int k = 0; k < nw; k++)
                if (txbuf[4+k] !== 16'(v.wdata >> ((nw - 1 - k) * 16))) pay_ok = 1'b0;
            chk(pay_ok, "R2", "write payload order", txbuf[4], 16'(v.wdata >> ((nw - 1) * 16)));
        end
    endtask

    task automatic send_flit(input logic [15:0] f, input logic l);
        @(negedge clk);
        rx_valid = 1'b1; rx_flit = f; rx_last = l;
    endtask

    task automatic rx_idle();
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        #1;
    endtask

    task automatic send_rsp(input vec_t v);
        int nf = 3 + int'(v.rnw);
        for (int k = 0; k < nf; k++) begin
            logic [15:0] f;
            if (k == 0)      f = v.rdst;
            else if (k == 1) f = v.rsrc;
            else if (k == 2) f = {v.rtype, v.rsub};
            else             f = 16'(v.rval >> ((int'(v.rnw) - 1 - (k - 3)) * 16));
            send_flit(f, k == nf - 1);
        end
        rx_idle();
    endtask

    task automatic run_vec(input vec_t v);
        int n;
        string t = tag_of(v);
        issue(v.wr, v.width, v.addr, v.wdata);
        collect(n);
        check_req(v, n);
        send_rsp(v);
        chk(done === 1'b1, "R12", "done after last reply flit", done, 1);
        chk(err === v.eerr, t, "error code", err, v.eerr);
        chk(ok === (v.eerr == 3'd0), "R12", "ok flag", ok, v.eerr == 3'd0);
        chk(rdata === v.erdata, t, "read value", rdata, v.erdata);
        @(negedge clk); #1;
        chk(done === 1'b0, "R12", "done is one cycle", done, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        int n, cnt;
        repeat (4) @(negedge clk);
        #1;
        chk(cmd_ready === 1'b1 && tx_valid === 1'b0, "R12", "ready/valid in reset", {cmd_ready, tx_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk({done, ok, err} === 5'b0, "R12", "status after reset", {done, ok, err}, 0);
        chk(rx_ready === 1'b1, "R10", "reply input ready", rx_ready, 1);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R4: unsupported widths
        issue(1'b0, 8'd48, 16'h0001, 128'h0);
        #1;
        chk(done === 1'b1 && err === 3'd1 && ok === 1'b0, "R4", "width 48 rejected", {done, ok, err}, 5'b10001);
        cnt = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            if (tx_valid) cnt++;
        end
        chk(cnt == 0, "R4", "no flit for bad width", cnt, 0);
        issue(1'b1, 8'd0, 16'h0001, 128'h1);
        #1;
        chk(done === 1'b1 && err === 3'd1 && tx_valid === 1'b0, "R4", "width 0 rejected", {done, tx_valid, err}, 5'b10001);

        // R9: no reply
        issue(1'b0, 8'd16, 16'h0055, 128'h0);
        collect(n);
        cnt = 0;
        do begin
            @(negedge clk); #1;
            cnt++;
        end while (!done && cnt < 200);
        chk(cnt == TMO + 1, "R9", "timeout latency", cnt, TMO + 1);
        chk(err === 3'd7 && ok === 1'b0, "R9", "timeout code", err, 7);

        // R10: late reply arriving while idle is discarded
        send_rsp(VECS[0]);
        chk(done === 1'b0, "R10", "late reply ignored", done, 0);
        @(negedge clk); #1;
        chk(done === 1'b0 && err === 3'd7, "R10", "status kept after late reply", {done, err}, 4'd7);
        run_vec(VECS[2]);

        // R10: tail of a packet begun before the wait is discarded
        send_flit(OWN, 1'b0);
        send_flit(TGT, 1'b0);
        rx_idle();
        issue(1'b0, 8'd32, 16'h0011, 128'h0);
        collect(n);
        send_flit(OWN, 1'b1);
        rx_idle();
        chk(done === 1'b0, "R10", "stray tail not taken as reply", done, 0);
        send_rsp(VECS[1]);
        chk(done === 1'b1 && err === 3'd0, "R10", "reply after stray tail", {done, err}, 4'b1000);
        chk(rdata === 128'h1234_5678, "R10", "value after stray tail", rdata, 128'h1234_5678);

        summary();
        $finish;
    end
endmodule